// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block keeps the coherence state of every line in one small direct-mapped write-back cache that sits on a shared snooping bus. The processor side presents one request at a time: a read or a write, a line address and, for writes, one data word. The request stays asserted until the block answers with a done pulse. The block reports whether the line was already present (hit), and the processor is stalled for every cycle without done. On the bus side the block asks for the bus and issues reads, read-for-ownership, invalidates and write-backs. A bus transaction completes in the cycle in which the arbiter grants it. In the same way the block watches the transactions of other caches and answers them in the same cycle on a shared, a dirty and a supplied-data output.

Each line holds one of four states: Invalid, Shared, Exclusive or Modified. A clean line that only this cache holds can be written without any bus traffic. A line that may also sit in another cache needs a granted invalidate before the write. The bus gives one order to all transactions, and snooped transactions change line state ahead of the local processor. A Modified line that is displaced is written back before the new line is fetched.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: cpu_done, cpu_hit, bus_req, snp_shared and snp_dirty are low, and the first access to any address is a miss.
- R2: A read to a present line (any state other than Invalid, tag equal) completes in the cycle it is presented, with cpu_hit high, cpu_rdata equal to the line's data, and no bus transaction.
- R3: A read miss issues bus command 0 (read) at the requested address. On the granted cycle it completes with cpu_hit low and cpu_rdata equal to bus_rdata. The line fills Exclusive when bus_shared_in is low and Shared when it is high.
- R4: A write to an Exclusive line completes in the cycle it is presented, with no bus transaction, and leaves the line Modified.
- R5: A write to a Shared line issues bus command 2 (invalidate) at its address. It completes only in the granted cycle and then leaves the line Modified.
- R6: A write to a Modified line completes with no bus transaction and replaces the line data.
- R7: A write miss issues bus command 1 (read-exclusive) at the requested address. On grant it completes with cpu_hit low and leaves the line Modified, holding the written word.
- R8: When a miss displaces a Modified line, bus command 3 (write-back) carrying the displaced line's address and data is granted before the fill request. Exclusive or Shared lines are displaced with no bus traffic.
- R9: A snooped read (snp_cmd 0) of a Modified line drives snp_shared and snp_dirty high and snp_data with the line data in the same cycle, and the line becomes Shared.
- R10: A snooped read of an Exclusive or Shared line drives snp_shared high and snp_dirty low, and an Exclusive line becomes Shared.
- R11: A snooped read-exclusive (1) or invalidate (2) of a held line invalidates it; a Modified line also drives snp_dirty and snp_data on a read-exclusive. A snooped write-back (3), or any snoop of a line not held, drives no response and changes nothing.
- R12: When a snoop addresses the same index as the pending processor request in one cycle, the snoop alone updates the line: the processor request does not complete, issues no bus request that cycle and is re-evaluated afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request pending |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Line was present, valid with cpu_done |
| cpu_stall | output | 1 | Request pending and not completing |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done on reads |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Line address of the transaction |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Requested transaction completes this cycle |
| bus_shared_in | input | 1 | Another cache holds the line being filled |
| bus_rdata | input | DATA_W | Fill data from the bus |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache keeps or held a copy |
| snp_dirty | output | 1 | This cache supplies newer data than memory |
| snp_data | output | DATA_W | Supplied data, zero when snp_dirty is low |

## Verification
On every cycle the assertions check these rules: a write to an Exclusive line never requests the bus, and a fill or read-for-ownership is never requested while the displaced line is still Modified. A completion never coincides with a snoop to the same index, a snooped read of a Modified line always reports dirty and shared, and a snooped invalidation leaves the line Invalid on the next cycle. Other behaviour appears only across a sequence, so only the bench scenarios can show it. That covers the order of write-back and fill, the choice of Exclusive versus Shared on a fill, which later shows up as silent or invalidating writes, data passing from fills through writes to snoop supply, and the request that a conflicting snoop defers and that then needs a different bus command.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_RD  = 2'd0,
        BC_RDX = 2'd1,
        BC_INV = 2'd2,
        BC_WB  = 2'd3
    } bus_cmd_e;

    function automatic logic st_present(line_st_e s);
        return s != ST_I;
    endfunction

    function automatic line_st_e fill_state(logic is_write, logic others_share);
        if (is_write)
            return ST_M;
        return others_share ? ST_S : ST_E;
    endfunction

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                       clk,
    input  logic                       rst,
    // processor-side read port
    input  logic [IDX_W-1:0]           a_idx,
    output line_st_e                   a_st,
    output logic [TAG_W-1:0]           a_tag,
    output logic [DATA_W-1:0]          a_data,
    // snoop-side read port
    input  logic [IDX_W-1:0]           b_idx,
    output line_st_e                   b_st,
    output logic [TAG_W-1:0]           b_tag,
    output logic [DATA_W-1:0]          b_data,
    // snoop update (priority)
    input  logic                       s_we,
    input  logic [IDX_W-1:0]           s_idx,
    input  line_st_e                   s_st,
    // processor update
    input  logic                       c_we,
    input  logic [IDX_W-1:0]           c_idx,
    input  line_st_e                   c_st,
    input  logic                       c_tag_we,
    input  logic [TAG_W-1:0]           c_tag,
    input  logic                       c_data_we,
    input  logic [DATA_W-1:0]          c_data,
    // whole state vector for observation
    output logic [LINES-1:0][1:0]      st_all
);

    line_st_e            st_arr   [LINES];
    logic [TAG_W-1:0]    tag_arr  [LINES];
    logic [DATA_W-1:0]   data_arr [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_st_e          st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] data_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r   <= ST_I;
                tag_r  <= '0;
                data_r <= '0;
            end else if (s_we && s_idx == IDX_W'(i)) begin
                st_r <= s_st;
            end else if (c_we && c_idx == IDX_W'(i)) begin
                st_r <= c_st;
                if (c_tag_we)
                    tag_r <= c_tag;
                if (c_data_we)
                    data_r <= c_data;
            end
        end

        assign st_arr[i]   = st_r;
        assign tag_arr[i]  = tag_r;
        assign data_arr[i] = data_r;
        assign st_all[i]   = st_r;
    end

    assign a_st   = st_arr[a_idx];
    assign a_tag  = tag_arr[a_idx];
    assign a_data = data_arr[a_idx];
    assign b_st   = st_arr[b_idx];
    assign b_tag  = tag_arr[b_idx];
    assign b_data = data_arr[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               snp_valid,
    input  bus_cmd_e           snp_cmd,
    input  logic [TAG_W-1:0]   snp_tag,
    input  line_st_e           line_st,
    input  logic [TAG_W-1:0]   line_tag,
    input  logic [DATA_W-1:0]  line_data,
    output logic               hit,
    output logic               rsp_shared,
    output logic               rsp_dirty,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               upd_we,
    output line_st_e           upd_st
);

    assign hit = snp_valid && st_present(line_st) && (line_tag == snp_tag);

    always_comb begin
        rsp_shared = 1'b0;
        rsp_dirty  = 1'b0;
        upd_we     = 1'b0;
        upd_st     = line_st;
        if (hit) begin
            unique case (snp_cmd)
                BC_RD: begin
                    rsp_shared = 1'b1;
                    rsp_dirty  = (line_st == ST_M);
                    upd_we     = (line_st == ST_M) || (line_st == ST_E);
                    upd_st     = ST_S;
                end
                BC_RDX: begin
                    rsp_dirty = (line_st == ST_M);
                    upd_we    = 1'b1;
                    upd_st    = ST_I;
                end
                BC_INV: begin
                    upd_we = 1'b1;
                    upd_st = ST_I;
                end
                default: ;  // a foreign write-back cannot target a line held here
            endcase
        end
    end

    assign rsp_data = rsp_dirty ? line_data : '0;

    AST_M_SNOOP_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (hit && snp_cmd == BC_RD && line_st == ST_M) |-> (rsp_dirty && rsp_shared && rsp_data == line_data)); // R9

    AST_SNOOP_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (!rsp_shared && !rsp_dirty && !upd_we)); // R11

endmodule

// File: rtl/mesi_cpu_ctrl.sv
module mesi_cpu_ctrl
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [TAG_W-1:0]   cpu_tag,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               snp_conflict,
    input  line_st_e           line_st,
    input  logic [TAG_W-1:0]   line_tag,
    input  logic [DATA_W-1:0]  line_data,
    input  logic               bus_gnt,
    input  logic               bus_shared_in,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic               done,
    output logic               hit,
    output logic [DATA_W-1:0]  rdata,
    output logic               breq,
    output bus_cmd_e           bcmd,
    output logic [TAG_W-1:0]   btag,
    output logic [DATA_W-1:0]  bwdata,
    output logic               c_we,
    output line_st_e           c_st,
    output logic               c_tag_we,
    output logic               c_data_we,
    output logic [DATA_W-1:0]  c_data
);

    logic tag_match;
    logic go;
    logic granted;

    assign tag_match = st_present(line_st) && (line_tag == cpu_tag);
    assign go        = cpu_req && !snp_conflict;
    assign granted   = go && bus_gnt;
    assign rdata     = tag_match ? line_data : bus_rdata;

    always_comb begin
        done      = 1'b0;
        hit       = 1'b0;
        breq      = 1'b0;
        bcmd      = BC_RD;
        btag      = cpu_tag;
        bwdata    = '0;
        c_we      = 1'b0;
        c_st      = line_st;
        c_tag_we  = 1'b0;
        c_data_we = 1'b0;
        c_data    = cpu_wdata;
        if (go) begin
            if (tag_match) begin
                hit = 1'b1;
                if (!cpu_we) begin
                    done = 1'b1;
                end else if (line_st == ST_S) begin
                    breq = 1'b1;
                    bcmd = BC_INV;
                    if (granted) begin
                        done      = 1'b1;
                        c_we      = 1'b1;
                        c_st      = ST_M;
                        c_data_we = 1'b1;
                    end
                end else begin
                    // Exclusive or Modified: private copy, no bus traffic
                    done      = 1'b1;
                    c_we      = 1'b1;
                    c_st      = ST_M;
                    c_data_we = 1'b1;
                end
            end else if (line_st == ST_M) begin
                breq   = 1'b1;
                bcmd   = BC_WB;
                btag   = line_tag;
                bwdata = line_data;
                if (granted) begin
                    c_we = 1'b1;
                    c_st = ST_I;
                end
            end else begin
                breq = 1'b1;
                bcmd = cpu_we ? BC_RDX : BC_RD;
                if (granted) begin
                    done      = 1'b1;
                    c_we      = 1'b1;
                    c_st      = fill_state(cpu_we, bus_shared_in);
                    c_tag_we  = 1'b1;
                    c_data_we = 1'b1;
                    c_data    = cpu_we ? cpu_wdata : bus_rdata;
                end
            end
        end
    end

    AST_E_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && tag_match && line_st == ST_E) |-> !breq); // R4

    AST_S_WRITE_WAITS: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && tag_match && line_st == ST_S && !bus_gnt) |-> !done); // R5

    AST_FILL_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        (breq && (bcmd == BC_RD || bcmd == BC_RDX)) |-> (line_st != ST_M)); // R8

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LINES  = 4,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_done,
    output logic               cpu_hit,
    output logic               cpu_stall,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               bus_req,
    output logic [1:0]         bus_cmd,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_gnt,
    input  logic               bus_shared_in,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [ADDR_W-1:0]  snp_addr,
    output logic               snp_shared,
    output logic               snp_dirty,
    output logic [DATA_W-1:0]  snp_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    line_st_e          a_st, b_st, s_st, c_st;
    logic [TAG_W-1:0]  a_tag, b_tag, c_tag_unused_n, btag;
    logic [DATA_W-1:0] a_data, b_data, c_data;
    logic              s_we, c_we, c_tag_we, c_data_we;
    logic              snp_hit, snp_conflict;
    bus_cmd_e          bcmd;
    logic [LINES-1:0][1:0] st_all;

    assign c_tag_unused_n = cpu_tag;
    assign snp_conflict   = snp_valid && (snp_idx == cpu_idx);

    mesi_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk      (clk),
        .rst      (rst),
        .a_idx    (cpu_idx),
        .a_st     (a_st),
        .a_tag    (a_tag),
        .a_data   (a_data),
        .b_idx    (snp_idx),
        .b_st     (b_st),
        .b_tag    (b_tag),
        .b_data   (b_data),
        .s_we     (s_we),
        .s_idx    (snp_idx),
        .s_st     (s_st),
        .c_we     (c_we),
        .c_idx    (cpu_idx),
        .c_st     (c_st),
        .c_tag_we (c_tag_we),
        .c_tag    (c_tag_unused_n),
        .c_data_we(c_data_we),
        .c_data   (c_data),
        .st_all   (st_all)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) snoop_i (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_e'(snp_cmd)),
        .snp_tag   (snp_tag),
        .line_st   (b_st),
        .line_tag  (b_tag),
        .line_data (b_data),
        .hit       (snp_hit),
        .rsp_shared(snp_shared),
        .rsp_dirty (snp_dirty),
        .rsp_data  (snp_data),
        .upd_we    (s_we),
        .upd_st    (s_st)
    );

    mesi_cpu_ctrl #(.TAG_W(TAG_W), .DATA_W(DATA_W)) cpu_i (
        .clk          (clk),
        .rst          (rst),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_tag      (cpu_tag),
        .cpu_wdata    (cpu_wdata),
        .snp_conflict (snp_conflict),
        .line_st      (a_st),
        .line_tag     (a_tag),
        .line_data    (a_data),
        .bus_gnt      (bus_gnt),
        .bus_shared_in(bus_shared_in),
        .bus_rdata    (bus_rdata),
        .done         (cpu_done),
        .hit          (cpu_hit),
        .rdata        (cpu_rdata),
        .breq         (bus_req),
        .bcmd         (bcmd),
        .btag         (btag),
        .bwdata       (bus_wdata),
        .c_we         (c_we),
        .c_st         (c_st),
        .c_tag_we     (c_tag_we),
        .c_data_we    (c_data_we),
        .c_data       (c_data)
    );

    assign bus_cmd   = bcmd;
    assign bus_addr  = {btag, cpu_idx};
    assign cpu_stall = cpu_req && !cpu_done;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cpu_hit && !snp_shared && !snp_dirty)); // R1

    AST_SNOOP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        snp_conflict |-> (!cpu_done && !bus_req)); // R12

    AST_SNOOP_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
        (snp_hit && (snp_cmd == 2'd1 || snp_cmd == 2'd2))
        |=> (st_all[$past(snp_idx)] == 2'd0)); // R11

endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
module mesi_line_ctrl_tb_top;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NL = 4;

    localparam logic [1:0] C_RD  = 2'd0;
    localparam logic [1:0] C_RDX = 2'd1;
    localparam logic [1:0] C_INV = 2'd2;
    localparam logic [1:0] C_WB  = 2'd3;

    localparam logic [1:0] M_I = 2'd0;
    localparam logic [1:0] M_S = 2'd1;
    localparam logic [1:0] M_E = 2'd2;
    localparam logic [1:0] M_M = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;  // 250 MHz

    logic          cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_done, cpu_hit, cpu_stall;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_gnt = 0;
    logic          bus_shared_in = 0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_shared, snp_dirty;
    logic [DW-1:0] snp_data;

    mesi_line_ctrl #(.ADDR_W(AW), .LINES(NL), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_dirty(snp_dirty), .snp_data(snp_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct { logic [1:0] cmd; logic [AW-1:0] addr; logic [DW-1:0] data; string req; } bus_item_t;
    typedef struct { logic hit; logic we; logic [DW-1:0] data; string req; } cpu_item_t;
    typedef struct { logic sh; logic dt; logic [DW-1:0] data; string req; } snp_item_t;

    bus_item_t bus_q[$];
    cpu_item_t cpu_q[$];
    snp_item_t snp_q[$];

    // reference model of the line table
    logic [1:0]        m_st  [NL];
    logic [AW-3:0]     m_tag [NL];
    logic [DW-1:0]     m_dat [NL];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bus stub: grants a pending request one cycle after it appears
    always @(posedge clk) begin
        if (rst) bus_gnt <= 1'b0;
        else     bus_gnt <= bus_req && !bus_gnt;
    end

    // monitors (sample at falling edge)
    always @(negedge clk) begin
        if (!rst && bus_req && bus_gnt) begin
            if (bus_q.size() == 0) begin
                check(0, "R4/R6", "unexpected bus transaction cmd", DW'(bus_cmd), '0);
            end else begin
                bus_item_t e;
                e = bus_q.pop_front();
                check(bus_cmd == e.cmd, e.req, "bus cmd", DW'(bus_cmd), DW'(e.cmd));
                check(bus_addr == e.addr, e.req, "bus addr", DW'(bus_addr), DW'(e.addr));
                if (e.cmd == C_WB)
                    check(bus_wdata == e.data, e.req, "write-back data", bus_wdata, e.data);
            end
        end
        if (!rst && cpu_req && cpu_done) begin
            if (cpu_q.size() == 0) begin
                check(0, "R12", "unexpected completion", DW'(cpu_done), '0);
            end else begin
                cpu_item_t c;
                c = cpu_q.pop_front();
                check(cpu_hit == c.hit, c.req, "cpu hit", DW'(cpu_hit), DW'(c.hit));
                if (!c.we)
                    check(cpu_rdata == c.data, c.req, "cpu read data", cpu_rdata, c.data);
            end
        end
        if (!rst && snp_valid) begin
            if (snp_q.size() != 0) begin
                snp_item_t s;
                s = snp_q.pop_front();
                check(snp_shared == s.sh, s.req, "snoop shared", DW'(snp_shared), DW'(s.sh));
                check(snp_dirty == s.dt, s.req, "snoop dirty", DW'(snp_dirty), DW'(s.dt));
                check(snp_data == s.data, s.req, "snoop data", snp_data, s.data);
            end
        end
    end

    // model: apply a snoop, return expected response
    task automatic model_snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input string req);
        snp_item_t s;
        int i;
        bit held;
        i = int'(a[1:0]);
        held = (m_st[i] != M_I) && (m_tag[i] == a[AW-1:2]);
        s.sh = 0; s.dt = 0; s.data = '0; s.req = req;
        if (held) begin
            if (cmd == C_RD) begin
                s.sh = 1;
                s.dt = (m_st[i] == M_M);
                if (m_st[i] == M_M || m_st[i] == M_E) m_st[i] = M_S;
            end else if (cmd == C_RDX) begin
                s.dt = (m_st[i] == M_M);
                m_st[i] = M_I;
            end else if (cmd == C_INV) begin
                m_st[i] = M_I;
            end
            if (s.dt) s.data = m_dat[i];
        end
        snp_q.push_back(s);
    endtask

    // model: processor operation, push expected bus items and completion
    task automatic model_cpu(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                             input logic sh, input logic [DW-1:0] fill, input string req);
        cpu_item_t c;
        bus_item_t b;
        int i;
        i = int'(a[1:0]);
        c.we = we; c.req = req;
        if (m_st[i] != M_I && m_tag[i] == a[AW-1:2]) begin
            c.hit = 1; c.data = m_dat[i];
            if (we) begin
                if (m_st[i] == M_S) begin
                    b.cmd = C_INV; b.addr = a; b.data = '0; b.req = req;
                    bus_q.push_back(b);
                end
                m_st[i] = M_M; m_dat[i] = wd;
            end
        end else begin
            if (m_st[i] == M_M) begin
                b.cmd = C_WB; b.addr = {m_tag[i], a[1:0]}; b.data = m_dat[i]; b.req = req;
                bus_q.push_back(b);
            end
            b.cmd = we ? C_RDX : C_RD; b.addr = a; b.data = '0; b.req = req;
            bus_q.push_back(b);
            c.hit = 0; c.data = fill;
            m_tag[i] = a[AW-1:2];
            m_st[i]  = we ? M_M : (sh ? M_S : M_E);
            m_dat[i] = we ? wd : fill;
        end
        cpu_q.push_back(c);
    endtask

    task automatic wait_done();
        forever begin
            @(negedge clk);
            if (cpu_done) break;
        end
        @(posedge clk); #1;
        cpu_req = 0;
        snp_valid = 0;
    endtask

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic sh, input logic [DW-1:0] fill, input string req);
        model_cpu(we, a, wd, sh, fill, req);
        bus_shared_in = sh; bus_rdata = fill;
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1;
        wait_done();
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input string req);
        model_snoop(cmd, a, req);
        snp_cmd = cmd; snp_addr = a; snp_valid = 1;
        @(posedge clk); #1;
        snp_valid = 0;
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin m_st[i] = M_I; m_tag[i] = '0; m_dat[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        check(!cpu_done && !bus_req && !snp_shared && !snp_dirty && !cpu_hit, "R1",
              "idle outputs after reset", DW'({cpu_done, bus_req, snp_shared, snp_dirty}), '0);
        @(posedge clk); #1;

        cpu_op(0, 6'h05, '0, 0, 16'hA1A1, "R1");   // first access misses, fills Exclusive (R3)
        cpu_op(0, 6'h05, '0, 0, 16'h0000, "R2");   // read hit
        cpu_op(1, 6'h05, 16'h1111, 0, '0, "R4");   // silent upgrade E->M
        cpu_op(1, 6'h05, 16'h2222, 0, '0, "R6");   // M write, no traffic
        cpu_op(0, 6'h05, '0, 0, '0, "R6");         // read back written data
        cpu_op(0, 6'h06, '0, 1, 16'hB0B0, "R3");   // fill Shared
        cpu_op(1, 6'h06, 16'h3333, 0, '0, "R5");   // invalidate then M

        snoop(C_RD, 6'h05, "R9");                  // M supplies, becomes S
        cpu_op(1, 6'h05, 16'h4444, 0, '0, "R9");   // needs INV now
        snoop(C_INV, 6'h05, "R11");
        cpu_op(0, 6'h05, '0, 1, 16'hC0C0, "R11");  // misses again, fills S
        snoop(C_RD, 6'h09, "R11");                 // not held: no response
        snoop(C_WB, 6'h05, "R11");                 // foreign write-back ignored
        cpu_op(0, 6'h05, '0, 0, '0, "R11");        // still present

        cpu_op(1, 6'h0A, 16'h5555, 0, '0, "R8");   // evicts M line 0x06, RDX (R7)
        cpu_op(0, 6'h1A, '0, 0, 16'hD0D0, "R8");   // evicts M line 0x0A, fills E
        cpu_op(0, 6'h0A, '0, 0, 16'hE0E0, "R8");   // E victim dropped silently
        snoop(C_RD, 6'h0A, "R10");                 // E -> S, clean
        cpu_op(1, 6'h0A, 16'h6666, 0, '0, "R10");  // S write needs INV
        snoop(C_RDX, 6'h0A, "R11");                // M supplies and invalidates
        cpu_op(1, 6'h03, 16'h7777, 0, '0, "R7");   // write miss

        // R12: snoop and processor to the same index in one cycle
        cpu_op(0, 6'h0B, '0, 0, 16'hF0F0, "R12");  // 0x0B fills E at index 3? no: index 3 holds 0x03 (M)
        model_snoop(C_RD, 6'h0B, "R12");           // snoop applied first: E -> S
        model_cpu(1, 6'h0B, 16'h8888, 0, '0, "R12"); // then the write needs INV
        snp_cmd = C_RD; snp_addr = 6'h0B; snp_valid = 1;
        cpu_we = 1; cpu_addr = 6'h0B; cpu_wdata = 16'h8888; cpu_req = 1;
        @(negedge clk);
        check(!cpu_done && !bus_req, "R12", "request held back during snoop",
              DW'({cpu_done, bus_req}), '0);
        @(posedge clk); #1;
        snp_valid = 0;
        wait_done();

        repeat (3) @(posedge clk);
        check(bus_q.size() == 0, "R8", "bus items left", DW'(bus_q.size()), '0);
        check(cpu_q.size() == 0, "R2", "completions left", DW'(cpu_q.size()), '0);
        check(snp_q.size() == 0, "R9", "snoop items left", DW'(snp_q.size()), '0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired: actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule